// File: doc/BRIEF.md
# Cache Address-Range Maintenance Sequencer

This block takes one cache maintenance command that covers a span of virtual addresses and breaks it into single-line requests, one 32-byte line at a time. There are four commands: invalidate in the instruction cache, invalidate in the data cache, clean in the data cache, and clean-and-invalidate in the data cache. The command is selected by a 4-bit code. A line request moves to the cache or translation stage over a valid/ready handshake. With the accepted line, that stage reports whether translating the line's address faulted.

The span is inclusive at both ends and is counted in whole lines. The lowest line is the one that holds the start address and the highest is the one that holds the end address. If the start line lies above the end line, nothing is issued and completion is reported at once. An interrupt can end the walk at any line boundary. No position is kept, so a resumed command runs again from its start line. A translation fault ends the walk with an abort, and the faulting line address is captured. In user mode only the data-clean command is accepted. Locked-down lines are not treated differently.

Top module: `cache_range_walker`

## Requirements
- R1: The operation code 5 issues lines with `line_op`=0 (instruction invalidate). Code 6 gives 1 (data invalidate), code 12 gives 2 (data clean) and code 14 gives 3 (data clean-and-invalidate). Any other code raises `undef_op` for one cycle and issues nothing.
- R2: Every issued `line_addr` has bits 4:0 at zero. The first line issued is `start_addr` with bits 4:0 cleared, and it appears the cycle after the start is accepted.
- R3: Lines are issued in ascending order, 32 bytes apart, up to and including the line that holds `end_addr`. `done` is high for one cycle, the cycle after the last line is accepted.
- R4: If the start line is above the end line, no line is issued, and `done` pulses the cycle after the start is accepted while `busy` stays low.
- R5: If `intr` is high while busy and the cycle has no faulting acceptance, the walk stops. `busy` falls the next cycle and `done` does not pulse. A line accepted in that same cycle still completes. A new start reissues from the start line.
- R6: If a line is accepted with `line_fault` high, `aborted` pulses the next cycle and `fault_addr` holds that line address. `busy` falls, and no further line and no `done` follow.
- R7: In user mode (`user_mode`=1), only code 12 starts a walk. The codes 5, 6 and 14 raise `undef_op` and leave `busy` low.
- R8: `busy` is high from the cycle after a start is accepted until the cycle in which `done` or `aborted` appears. A start while busy is ignored.
- R9: While `line_valid` is high and `line_ready` is low, with no interrupt, `line_valid` stays high and `line_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, taken when not busy |
| op_code | input | 4 | Command code (5, 6, 12, 14) |
| start_addr | input | 32 | Lowest address of the span |
| end_addr | input | 32 | Highest address of the span |
| user_mode | input | 1 | Issuer runs unprivileged |
| intr | input | 1 | Interrupt: stop at the next line boundary |
| line_ready | input | 1 | Downstream accepts the current line |
| line_fault | input | 1 | Translation of the accepted line faulted |
| line_valid | output | 1 | A line request is presented |
| line_addr | output | 32 | Line-aligned address of the request |
| line_op | output | 2 | Operation for the line (see R1) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: span completed |
| aborted | output | 1 | One-cycle pulse: walk ended on a fault |
| undef_op | output | 1 | One-cycle pulse: command rejected |
| fault_addr | output | 32 | Line address of the most recent fault |

## Verification
The case that is hardest to reach is an interrupt that arrives in the same cycle as a line acceptance partway through a walk. To reach it, the ready input is held high continuously, so acceptances land on known edges, and the interrupt is raised just after a chosen edge. The scoreboard then expects exactly the lines up to and including the one taken alongside the interrupt. A second run holds ready low to freeze the request, raises the interrupt, and then restarts the command. This shows that the replay starts again from the start line.

// File: rtl/crw_pkg.sv
package crw_pkg;
  typedef enum logic [1:0] {
    OP_IINV   = 2'd0,
    OP_DINV   = 2'd1,
    OP_DCLEAN = 2'd2,
    OP_DCINV  = 2'd3
  } maint_op_e;

  // Code values recognised on the command input.
  function automatic logic code_known(input logic [3:0] code);
    return (code == 4'd5) || (code == 4'd6) || (code == 4'd12) || (code == 4'd14);
  endfunction

  function automatic maint_op_e code_to_op(input logic [3:0] code);
    case (code)
      4'd5:    return OP_IINV;
      4'd6:    return OP_DINV;
      4'd12:   return OP_DCLEAN;
      default: return OP_DCINV;
    endcase
  endfunction

  // Only the data clean is allowed without privilege.
  function automatic logic user_allowed(input maint_op_e op);
    return op == OP_DCLEAN;
  endfunction
endpackage

// File: rtl/crw_decode.sv
module crw_decode
  import crw_pkg::*;
(
  input  logic [3:0] code,
  input  logic       user,
  output maint_op_e  op,
  output logic       reject
);
  always_comb begin
    op     = code_to_op(code);
    reject = !code_known(code) || (user && !user_allowed(op));
  end
endmodule

// File: rtl/crw_line_ctr.sv
module crw_line_ctr #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic [ADDR_W-1:0] cur_line,
  output logic              at_end,
  output logic              range_rev
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << OFS_W;

  function automatic logic [ADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] cur_q, end_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0;
      end_q <= '0;
    end else if (load) begin
      cur_q <= line_of(first_addr);
      end_q <= line_of(last_addr);
    end else if (step) begin
      cur_q <= cur_q + STRIDE;
    end
  end

  assign cur_line  = cur_q;
  assign at_end    = (cur_q == end_q);
  assign range_rev = line_of(first_addr) > line_of(last_addr);
endmodule

// File: rtl/crw_fsm.sv
module crw_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic start_take,
  input  logic reject,
  input  logic range_rev,
  input  logic line_acc,
  input  logic line_fault,
  input  logic at_end,
  input  logic intr,
  output logic walking,
  output logic load,
  output logic step,
  output logic capture,
  output logic done_q,
  output logic abort_q,
  output logic undef_q
);
  typedef enum logic {S_IDLE, S_WALK} st_e;
  st_e st;

  assign walking = (st == S_WALK);
  assign load    = (st == S_IDLE) && start_take && !reject && !range_rev;
  assign capture = walking && line_acc && line_fault;
  assign step    = walking && line_acc && !line_fault && !at_end && !intr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      undef_q <= 1'b0;
      case (st)
        S_IDLE: if (start_take) begin
          if (reject)         undef_q <= 1'b1;
          else if (range_rev) done_q  <= 1'b1;
          else                st      <= S_WALK;
        end
        S_WALK: begin
          if (line_acc) begin
            if (line_fault) begin
              abort_q <= 1'b1;
              st      <= S_IDLE;
            end else if (at_end) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else if (intr) begin
              st <= S_IDLE;
            end
          end else if (intr) begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_range_walker.sv
module cache_range_walker
  import crw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic              user_mode,
  input  logic              intr,
  input  logic              line_ready,
  input  logic              line_fault,
  output logic              line_valid,
  output logic [ADDR_W-1:0] line_addr,
  output logic [1:0]        line_op,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic              undef_op,
  output logic [ADDR_W-1:0] fault_addr
);
  // Named internal events, visible to the bound checker.
  logic      start_take, line_acc, reject, range_rev, at_end;
  logic      walking, load, step, capture;
  maint_op_e dec_op, op_q;
  logic [ADDR_W-1:0] cur_line, fault_q;

  assign start_take = start && !walking;
  assign line_acc   = walking && line_ready;

  crw_decode u_dec (
    .code(op_code), .user(user_mode), .op(dec_op), .reject(reject)
  );

  crw_line_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .first_addr(start_addr), .last_addr(end_addr),
    .cur_line(cur_line), .at_end(at_end), .range_rev(range_rev)
  );

  crw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_take(start_take), .reject(reject),
    .range_rev(range_rev), .line_acc(line_acc), .line_fault(line_fault),
    .at_end(at_end), .intr(intr), .walking(walking), .load(load),
    .step(step), .capture(capture), .done_q(done), .abort_q(aborted),
    .undef_q(undef_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_IINV;
      fault_q <= '0;
    end else begin
      if (load)    op_q    <= dec_op;
      if (capture) fault_q <= cur_line;
    end
  end

  assign line_valid = walking;
  assign busy       = walking;
  assign line_addr  = cur_line;
  assign line_op    = op_q;
  assign fault_addr = fault_q;
endmodule

// File: rtl/crw_chk.sv
module crw_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [3:0]        op_code,
  input logic              user_mode,
  input logic              intr,
  input logic              line_ready,
  input logic              line_fault,
  input logic              line_valid,
  input logic [ADDR_W-1:0] line_addr,
  input logic              busy,
  input logic              done,
  input logic              aborted,
  input logic              undef_op,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              line_acc,
  input logic              range_rev,
  input logic              at_end
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << OFS_W;

  // R2
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> line_addr[OFS_W-1:0] == '0);

  // R3
  line_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_acc && !line_fault && !at_end && !intr) |=>
      (line_valid && line_addr == $past(line_addr) + STRIDE));

  // R3
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_acc && !line_fault && at_end) |=> (done && !busy));

  // R4
  reversed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_code == 4'd12 && range_rev) |=> (done && !busy));

  // R5
  intr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && intr && !line_acc) |=> (!busy && !done));

  // R6
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_acc && line_fault) |=>
      (aborted && !busy && !done && fault_addr == $past(line_addr)));

  // R7
  user_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && user_mode && (op_code == 4'd5 || op_code == 4'd6 || op_code == 4'd14))
      |=> (undef_op && !busy));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_ready && !intr) |=> (line_valid && $stable(line_addr)));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, aborted, undef_op}));
endmodule

bind cache_range_walker crw_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
  .user_mode(user_mode), .intr(intr), .line_ready(line_ready),
  .line_fault(line_fault), .line_valid(line_valid), .line_addr(line_addr),
  .busy(busy), .done(done), .aborted(aborted), .undef_op(undef_op),
  .fault_addr(fault_addr), .line_acc(line_acc), .range_rev(range_rev),
  .at_end(at_end)
);

// File: tb/cache_range_walker_test.sv
module cache_range_walker_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, user_mode = 1'b0, intr = 1'b0, line_ready = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [31:0] start_addr = '0, end_addr = '0;
  logic        line_fault, line_valid, busy, done, aborted, undef_op;
  logic [31:0] line_addr, fault_addr;
  logic [1:0]  line_op;

  logic        flt_en = 1'b0;
  logic [31:0] flt_line = '0;
  int          rdy_mode = 0;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_done = 0, n_abort = 0, n_undef = 0, n_acc = 0, last_acc = 0, done_at = 0;
  logic [33:0] expq[$];

  always #10 clk = ~clk;  // 50 MHz

  cache_range_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
    .start_addr(start_addr), .end_addr(end_addr), .user_mode(user_mode),
    .intr(intr), .line_ready(line_ready), .line_fault(line_fault),
    .line_valid(line_valid), .line_addr(line_addr), .line_op(line_op),
    .busy(busy), .done(done), .aborted(aborted), .undef_op(undef_op),
    .fault_addr(fault_addr)
  );

  assign line_fault = flt_en && line_valid && (line_addr == flt_line);

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_op(input logic [3:0] c);
    case (c)
      4'd5: return 2'd0; 4'd6: return 2'd1; 4'd12: return 2'd2; default: return 2'd3;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      summary();
      $finish;
    end
  end

  // Ready pattern driver: 0 always ready, 1 alternating, 2 never.
  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: line_ready = 1'b1;
      1: line_ready = ~line_ready;
      default: line_ready = 1'b0;
    endcase
  end

  // Monitor: compares each accepted line with the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && line_valid && line_ready) begin
      if (expq.size() == 0) chk(1'b0, "R3 unexpected line", {line_op, line_addr}, '0);
      else begin
        logic [33:0] e;
        e = expq.pop_front();
        chk({line_op, line_addr} == e, "R1/R2/R3 line", {line_op, line_addr}, e);
      end
      n_acc++; last_acc = cyc;
    end
    if (done)     begin n_done++; done_at = cyc; end
    if (aborted)  n_abort++;
    if (undef_op) n_undef++;
  end

  // kind: 0 done, 1 abort, 2 rejected
  task automatic run_walk(input logic [3:0] c, input logic [31:0] s, input logic [31:0] e,
                          input bit usr, input int kind, input bit poke, input string req);
    logic [31:0] ln, el;
    int d0, a0, u0, acc0, it;
    ln = s & ~32'd31; el = e & ~32'd31;
    if (kind != 2 && ln <= el) begin
      forever begin
        expq.push_back({exp_op(c), ln});
        if (kind == 1 && ln == flt_line) break;
        if (ln == el) break;
        ln += 32;
      end
    end
    d0 = n_done; a0 = n_abort; u0 = n_undef; acc0 = n_acc;
    @(posedge clk); #2;
    start = 1'b1; op_code = c; start_addr = s; end_addr = e; user_mode = usr;
    @(posedge clk); #2;
    start = 1'b0;
    if (kind == 2)
      chk(undef_op && !busy, {req, " R7 reject pulse"}, {undef_op, busy}, 2'b10);
    else if ((s & ~32'd31) > (e & ~32'd31))
      chk(done && !busy && !line_valid, {req, " R4 immediate done"}, {done, busy, line_valid}, 3'b100);
    else
      chk(busy && line_addr == (s & ~32'd31), {req, " R2/R8 first line"}, {busy, line_addr}, {1'b1, s & ~32'd31});
    it = 0;
    while (n_done == d0 && n_abort == a0 && n_undef == u0 && it < 3000) begin
      @(posedge clk); #5;
      it++;
      if (poke && it == 2) begin start = 1'b1; op_code = 4'd5; start_addr = 32'h9000; end_addr = 32'h9400; end
      if (poke && it == 3) start = 1'b0;
    end
    repeat (2) @(posedge clk);
    #5;
    chk(!busy, {req, " R8 idle after"}, busy, 0);
    chk(expq.size() == 0, {req, " R3 all lines seen"}, expq.size(), 0);
    case (kind)
      0: chk(n_done == d0 + 1 && n_abort == a0, {req, " R3 done once"}, n_done - d0, 1);
      1: chk(n_abort == a0 + 1 && n_done == d0 && fault_addr == flt_line,
             {req, " R6 abort"}, {n_abort - a0, fault_addr}, {2'd1, flt_line});
      default: chk(n_undef == u0 + 1 && n_acc == acc0, {req, " R1/R7 nothing issued"}, n_acc - acc0, 0);
    endcase
    if (kind == 0 && n_acc > acc0)
      chk(done_at == last_acc + 1, {req, " R3 done timing"}, done_at, last_acc + 1);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #5;
    chk(!busy && !line_valid && !done && !aborted && !undef_op && fault_addr == 0,
        "reset state", {busy, line_valid, done, aborted, undef_op}, 0);

    rdy_mode = 0;
    run_walk(4'd5,  32'h0000_1004, 32'h0000_10E7, 1'b0, 0, 1'b0, "R1 icache inval");
    run_walk(4'd6,  32'h0000_2000, 32'h0000_2000, 1'b0, 0, 1'b0, "R3 single line");
    run_walk(4'd14, 32'h0000_301F, 32'h0000_3020, 1'b0, 0, 1'b0, "R2 unaligned ends");
    rdy_mode = 1;
    run_walk(4'd12, 32'h0000_4010, 32'h0000_41FF, 1'b0, 0, 1'b1, "R8 busy start ignored");
    rdy_mode = 0;
    run_walk(4'd6,  32'h0000_5040, 32'h0000_5020, 1'b0, 0, 1'b0, "R4 reversed");
    run_walk(4'd6,  32'h0000_5050, 32'h0000_5040, 1'b0, 0, 1'b0, "R4 same line reordered");
    run_walk(4'd12, 32'h0000_6000, 32'h0000_6060, 1'b1, 0, 1'b0, "R7 user clean");
    run_walk(4'd6,  32'h0000_6000, 32'h0000_6060, 1'b1, 2, 1'b0, "R7 user dinval");
    run_walk(4'd14, 32'h0000_6000, 32'h0000_6060, 1'b1, 2, 1'b0, "R7 user cinval");
    run_walk(4'd7,  32'h0000_6000, 32'h0000_6060, 1'b0, 2, 1'b0, "R1 bad code");
    flt_en = 1'b1; flt_line = 32'h0000_7060;
    run_walk(4'd14, 32'h0000_7000, 32'h0000_70E0, 1'b0, 1, 1'b0, "R6 fault mid walk");
    flt_en = 1'b0;

    // R9 stall then R5 interrupt with no acceptance, then restart from start.
    rdy_mode = 2;
    @(posedge clk); #2;
    start = 1'b1; op_code = 4'd6; start_addr = 32'h0000_8008; end_addr = 32'h0000_8070; user_mode = 1'b0;
    @(posedge clk); #2; start = 1'b0;
    repeat (4) @(posedge clk);
    #5;
    chk(line_valid && line_addr == 32'h0000_8000, "R9 stalled request held", {line_valid, line_addr}, {1'b1, 32'h8000});
    begin
      int d0;
      d0 = n_done;
      intr = 1'b1;
      @(posedge clk); #2; intr = 1'b0;
      chk(!busy, "R5 stop on interrupt", busy, 0);
      repeat (2) @(posedge clk);
      #5;
      chk(n_done == d0 && n_acc >= 0, "R5 no done after interrupt", n_done - d0, 0);
    end
    rdy_mode = 0;
    run_walk(4'd6, 32'h0000_8008, 32'h0000_8070, 1'b0, 0, 1'b0, "R5 restart full range");

    // R5 interrupt coinciding with the 4th acceptance.
    begin
      int d0;
      d0 = n_done;
      for (int k = 0; k < 4; k++) expq.push_back({2'd3, 32'h0000_A000 + 32'(k * 32)});
      @(posedge clk); #2;
      start = 1'b1; op_code = 4'd14; start_addr = 32'h0000_A000; end_addr = 32'h0000_A1E0;
      @(posedge clk); #2; start = 1'b0;
      repeat (3) @(posedge clk);
      #2 intr = 1'b1;
      @(posedge clk); #2 intr = 1'b0;
      chk(!busy, "R5 stop at boundary", busy, 0);
      repeat (2) @(posedge clk);
      #5;
      chk(expq.size() == 0, "R5 lines up to interrupt", expq.size(), 0);
      chk(n_done == d0, "R5 no done", n_done - d0, 0);
      expq.delete();
    end

    summary();
    $finish;
  end
endmodule